// File: doc/BRIEF.md
# Busy Ratio Normalizer

This block converts a pair of sampled cycle counts into a utilization figure on a fixed scale of 0 to 1000. The figure is the busy count times 1000 divided by the total count, with integer truncation. It then applies that figure to a separate elapsed-time word, which gives an estimate of busy time in the same units as the elapsed time. A power-management sequencer captures its activity counters, presents them with an overflow indication and the measured interval, pulses `start_i`, and reads the two results when `done_o` pulses.

Both divisions share one restoring shift-subtract divider that resolves one quotient bit per clock. The block does not run the divider when the result is known in advance. An overflow flag forces full scale and takes priority. After it, a zero total or a busy count above the total also forces full scale. In those cases the first division is skipped. The results stay on the outputs until the next computation completes.

Top module: `busy_ratio_norm`

## Requirements
- R1: When no saturation case applies, `ratio_o` equals floor(busy × 1000 / total) for 31-bit busy and total counts.
- R2: When `ovf_i` is 1 at the accepted start, `ratio_o` is 1000 whatever the counts are, including a zero total. Overflow is checked before the count cases.
- R3: When `ovf_i` is 0 and the total count is zero, `ratio_o` is 1000 and no ratio division runs.
- R4: When `ovf_i` is 0 and busy is strictly greater than total, `ratio_o` is 1000. Busy equal to total goes through the divider and also gives 1000.
- R5: `busy_time_o` equals floor(elapsed × ratio / 1000). The product of the 32-bit elapsed word and the ratio is kept at full width before the divide.
- R6: `done_o` is a single-cycle pulse. With divider width D = 42, it rises D+3 = 45 clock edges after the accepting edge when the ratio is saturated, and 2D+4 = 88 edges after it otherwise.
- R7: `start_i` is accepted only when no computation is in flight. A start during a computation has no effect. A start held during the `done_o` cycle is accepted at the next edge.
- R8: After reset `ratio_o`, `busy_time_o` and `done_o` are 0. `ratio_o` and `busy_time_o` change only at the edge that raises `done_o` and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a computation on the present inputs |
| ovf_i | input | 1 | Counter overflow indication, forces full scale |
| busy_cnt_i | input | 31 | Busy cycle count |
| total_cnt_i | input | 31 | Total cycle count |
| elapsed_i | input | 32 | Measured elapsed time |
| ratio_o | output | 10 | Normalized busy ratio, 0..1000 |
| busy_time_o | output | 32 | Elapsed time scaled by the ratio |
| done_o | output | 1 | One-cycle pulse when results are updated |

## Verification
The bench targets the following corner cases:
- **Overflow together with a zero total.** A design that tested the total before the flag would still give 1000 here, so the latency of the saturated path is checked as well.
- **Busy one above total and busy equal to total.** An off-by-one comparison either returns 1000 by the wrong path, with the wrong latency, or lets an over-range quotient through.
- **Full-width counts and the full 32-bit elapsed word.** These expose a truncated product or a narrow remainder as wrong low digits.
- **A start pulsed mid-computation and a start held in the done cycle.** A design that re-latched on the first would publish the second operand set, and one that missed the second would lose a request.

// File: rtl/brn_pkg.sv
package brn_pkg;

  parameter int unsigned BRN_SCALE = 1000;
  localparam int unsigned BRN_RATIO_W = $clog2(BRN_SCALE + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLASS,
    ST_RWAIT,
    ST_TLOAD,
    ST_TWAIT
  } brn_state_e;

  typedef enum logic [1:0] {
    SAT_NONE,
    SAT_OVF,
    SAT_ZERO,
    SAT_EXCESS
  } brn_sat_e;

endpackage

// File: rtl/brn_classify.sv
module brn_classify
  import brn_pkg::*;
#(
  parameter int unsigned CNT_W = 31
) (
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] busy_i,
  input  logic [CNT_W-1:0] total_i,
  output brn_sat_e         reason_o
);

  // Priority: overflow, then zero total, then busy above total.
  always_comb begin
    if (ovf_i)
      reason_o = SAT_OVF;
    else if (total_i == '0)
      reason_o = SAT_ZERO;
    else if (busy_i > total_i)
      reason_o = SAT_EXCESS;
    else
      reason_o = SAT_NONE;
  end

endmodule

// File: rtl/brn_divider.sv
module brn_divider #(
  parameter int unsigned W = 42
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         fin_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = ~trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
  assign fin_o = fin_q;

endmodule

// File: rtl/busy_ratio_norm.sv
module busy_ratio_norm
  import brn_pkg::*;
#(
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned TIME_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   ovf_i,
  input  logic [CNT_W-1:0]       busy_cnt_i,
  input  logic [CNT_W-1:0]       total_cnt_i,
  input  logic [TIME_W-1:0]      elapsed_i,
  output logic [BRN_RATIO_W-1:0] ratio_o,
  output logic [TIME_W-1:0]      busy_time_o,
  output logic                   done_o
);

  localparam int unsigned RW = BRN_RATIO_W;
  localparam int unsigned DW = ((CNT_W > TIME_W) ? CNT_W : TIME_W) + RW;

  function automatic logic [DW-1:0] scale_up(input logic [CNT_W-1:0] cnt);
    return DW'(cnt) * DW'(BRN_SCALE);
  endfunction

  function automatic logic [DW-1:0] time_product(input logic [TIME_W-1:0] t,
                                                 input logic [RW-1:0]     r);
    return DW'(t) * DW'(r);
  endfunction

  brn_state_e          state_q;
  logic                ovf_q;
  logic [CNT_W-1:0]    busy_q;
  logic [CNT_W-1:0]    total_q;
  logic [TIME_W-1:0]   elapsed_q;
  logic [RW-1:0]       ratio_work_q;
  logic [RW-1:0]       ratio_q;
  logic [TIME_W-1:0]   time_q;
  logic                done_q;

  // Named internal events for the checker.
  logic                accept_start;
  brn_sat_e            sat_reason;
  logic                sat_hit;
  logic                div_load;
  logic [DW-1:0]       div_num;
  logic [DW-1:0]       div_den;
  logic [DW-1:0]       div_quo;
  logic                div_fin;

  assign accept_start = (state_q == ST_IDLE) && start_i;

  brn_classify #(.CNT_W(CNT_W)) u_class (
    .ovf_i   (ovf_q),
    .busy_i  (busy_q),
    .total_i (total_q),
    .reason_o(sat_reason)
  );

  assign sat_hit = (sat_reason != SAT_NONE);

  always_comb begin
    div_load = 1'b0;
    div_num  = '0;
    div_den  = '0;
    case (state_q)
      ST_CLASS: begin
        if (!sat_hit) begin
          div_load = 1'b1;
          div_num  = scale_up(busy_q);
          div_den  = DW'(total_q);
        end
      end
      ST_TLOAD: begin
        div_load = 1'b1;
        div_num  = time_product(elapsed_q, ratio_work_q);
        div_den  = DW'(BRN_SCALE);
      end
      default: ;
    endcase
  end

  brn_divider #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(div_load),
    .num_i (div_num),
    .den_i (div_den),
    .quo_o (div_quo),
    .fin_o (div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      ovf_q        <= 1'b0;
      busy_q       <= '0;
      total_q      <= '0;
      elapsed_q    <= '0;
      ratio_work_q <= '0;
      ratio_q      <= '0;
      time_q       <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            ovf_q     <= ovf_i;
            busy_q    <= busy_cnt_i;
            total_q   <= total_cnt_i;
            elapsed_q <= elapsed_i;
            state_q   <= ST_CLASS;
          end
        end
        ST_CLASS: begin
          if (sat_hit) begin
            ratio_work_q <= RW'(BRN_SCALE);
            state_q      <= ST_TLOAD;
          end else begin
            state_q <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (div_fin) begin
            ratio_work_q <= div_quo[RW-1:0];
            state_q      <= ST_TLOAD;
          end
        end
        ST_TLOAD: state_q <= ST_TWAIT;
        ST_TWAIT: begin
          if (div_fin) begin
            ratio_q <= ratio_work_q;
            time_q  <= div_quo[TIME_W-1:0];
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ratio_o     = ratio_q;
  assign busy_time_o = time_q;
  assign done_o      = done_q;

endmodule

// File: rtl/brn_chk.sv
module brn_chk
  import brn_pkg::*;
#(
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned TIME_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   ovf_i,
  input logic [TIME_W-1:0]      elapsed_i,
  input logic [BRN_RATIO_W-1:0] ratio_o,
  input logic [TIME_W-1:0]      busy_time_o,
  input logic                   done_o,
  input logic                   accept_start,
  input brn_sat_e               sat_reason,
  input logic                   div_load,
  input logic                   div_fin
);

  logic              inflight_q;
  logic              ovf_seen_q;
  logic [TIME_W-1:0] elapsed_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q     <= 1'b0;
      ovf_seen_q     <= 1'b0;
      elapsed_seen_q <= '0;
    end else if (accept_start) begin
      inflight_q     <= 1'b1;
      ovf_seen_q     <= ovf_i;
      elapsed_seen_q <= elapsed_i;
    end else if (done_o) begin
      inflight_q <= 1'b0;
    end
  end

  // R1
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ratio_o <= BRN_RATIO_W'(BRN_SCALE)));

  // R2
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && inflight_q && ovf_seen_q) |-> (ratio_o == BRN_RATIO_W'(BRN_SCALE)));

  // R3
  sat_no_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_reason == SAT_ZERO && inflight_q && !div_fin && !done_o && $rose(inflight_q)) |-> !div_load);

  // R5
  time_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && inflight_q) |-> (busy_time_o <= elapsed_seen_q));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  div_fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |=> !div_fin);

  // R7
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q && !done_o && start_i) |-> !accept_start);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(ratio_o) && $stable(busy_time_o)));

endmodule

bind busy_ratio_norm brn_chk #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_brn_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ovf_i       (ovf_i),
  .elapsed_i   (elapsed_i),
  .ratio_o     (ratio_o),
  .busy_time_o (busy_time_o),
  .done_o      (done_o),
  .accept_start(accept_start),
  .sat_reason  (sat_reason),
  .div_load    (div_load),
  .div_fin     (div_fin)
);

// File: tb/tb_busy_ratio_norm.sv
module tb_busy_ratio_norm;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_BITS   = 42;
  localparam int LAT_SAT    = DIV_BITS + 3;
  localparam int LAT_DIV    = 2 * DIV_BITS + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic [30:0] busy_cnt_i = '0;
  logic [30:0] total_cnt_i = '0;
  logic [31:0] elapsed_i = '0;
  logic [9:0]  ratio_o;
  logic [31:0] busy_time_o;
  logic        done_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string cur_tag  = "R8";

  always #(CLK_PERIOD / 2) clk = ~clk;

  busy_ratio_norm dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ovf_i      (ovf_i),
    .busy_cnt_i (busy_cnt_i),
    .total_cnt_i(total_cnt_i),
    .elapsed_i  (elapsed_i),
    .ratio_o    (ratio_o),
    .busy_time_o(busy_time_o),
    .done_o     (done_o)
  );

  function automatic longint unsigned ref_ratio(input bit ovf, input longint unsigned b,
                                                input longint unsigned t);
    if (ovf) return 1000;
    if (t == 0) return 1000;
    if (b > t) return 1000;
    return (b * 1000) / t;
  endfunction

  function automatic bit ref_sat(input bit ovf, input longint unsigned b,
                                 input longint unsigned t);
    return ovf || (t == 0) || (b > t);
  endfunction

  // Reference model: pending result list and a countdown per request.
  bit              m_busy = 0;
  int              m_cnt = 0;
  bit              m_done = 0;
  longint unsigned m_ratio = 0, m_time = 0;
  longint unsigned p_ratio[$];
  longint unsigned p_time[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy  <= 0;
      m_cnt   <= 0;
      m_done  <= 0;
      m_ratio <= 0;
      m_time  <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_done  <= 1;
          m_busy  <= 0;
          m_ratio <= p_ratio.pop_front();
          m_time  <= p_time.pop_front();
        end
        m_cnt <= m_cnt - 1;
      end else if (start_i) begin
        longint unsigned r;
        r = ref_ratio(ovf_i, busy_cnt_i, total_cnt_i);
        p_ratio.push_back(r);
        p_time.push_back((longint'(elapsed_i) * r) / 1000);
        m_busy <= 1;
        m_cnt  <= ref_sat(ovf_i, busy_cnt_i, total_cnt_i) ? LAT_SAT : LAT_DIV;
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(m_done ? "R6" : cur_tag, "done_o", done_o, m_done);
      check(cur_tag, "ratio_o", ratio_o, m_ratio);
      check(m_done ? cur_tag : "R8", "busy_time_o", busy_time_o, m_time);
    end
    if (cycles > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) return;
    end
  endtask

  task automatic run(input string tag, input bit ovf, input longint unsigned b,
                     input longint unsigned t, input longint unsigned e);
    longint unsigned r;
    cur_tag     = tag;
    ovf_i       = ovf;
    busy_cnt_i  = 31'(b);
    total_cnt_i = 31'(t);
    elapsed_i   = 32'(e);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    r = ref_ratio(ovf, b, t);
    check(tag, "ratio at done", ratio_o, r);
    check("R5", "time at done", busy_time_o, (e * r) / 1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "reset ratio", ratio_o, 0);
    check("R8", "reset time", busy_time_o, 0);
    check("R8", "reset done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R1", 0, 333, 1000, 50000);
    run("R1", 0, 1, 3, 1000);
    run("R1", 0, 0, 12345, 777);
    run("R2", 1, 5, 100, 2000);
    run("R2", 1, 0, 0, 999);
    run("R3", 0, 7, 0, 4321);
    run("R4", 0, 101, 100, 3000);
    run("R4", 0, 100, 100, 3000);
    run("R1", 0, 31'h7FFF_FFFE, 31'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R4", 0, 31'h7FFF_FFFF, 31'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R5", 0, 999, 1000, 32'hFFFF_FFFF);

    // R7: start pulsed mid-computation with different operands is ignored.
    cur_tag     = "R7";
    ovf_i       = 0;
    busy_cnt_i  = 31'd250;
    total_cnt_i = 31'd1000;
    elapsed_i   = 32'd8000;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    busy_cnt_i  = 31'd9;
    total_cnt_i = 31'd0;
    ovf_i       = 1;
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    check("R7", "ignored start ratio", ratio_o, 250);
    check("R7", "ignored start time", busy_time_o, 2000);
    // R7: start held during the done cycle is accepted.
    run("R7", 0, 500, 1000, 10);
    run("R7", 0, 3, 4, 400);
    repeat (5) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule